// File: doc/BRIEF.md
# Built-in Test Fault Aggregator

This block gathers independent fault indications from the monitored parts of a recorder: verify failure, tape motion, the tape-end sensors, track selection, missing input data and processor lock-up. It qualifies each one on a slow sample strobe and combines the qualified faults through a fault gate. The gate drives an active-high maintenance flag and two active-low lamp lines, one for the OFF lamp and one for the external warning. A separate active-low front-panel LED line lights for every fault except missing input data.

A fault counts as current only after it has been seen on four consecutive sample strobes. Every current fault also sets a sticky history bit. The history image keeps intermittent faults that have since gone away. A shop-test port reads this image in parallel and can clear it with a one-cycle command. On request, a serializer sends a status word with the current faults in the low half and the history in the high half.

The serializer is a two-state machine. `SER_IDLE` waits for `ser_start`. On the transition IDLE→SHIFT it takes a snapshot of the word. `SER_SHIFT` puts out one bit per cycle. On the transition SHIFT→IDLE, taken after the last bit, it returns to idle. `ser_start` has no effect while the machine is in SHIFT.

Top module: `fault_aggregator`

## Requirements
- R1: Fault inputs are looked at only in cycles where `sample_tick` is high. While `sample_tick` is low, the current faults do not change, whatever `fault_in` holds.
- R2: Input bit k becomes a current fault at the clock edge of the fourth consecutive sample tick on which `fault_in[k]` is high. After three such ticks it is not yet current. Bit map: 0 verify, 1 motion, 2 end sensor, 3 begin sensor, 4 track select, 5 input-data loss, 6 lock-up.
- R3: A sample tick with `fault_in[k]` low clears that bit's current state and its count at once. A later fault on that bit needs four fresh consecutive ticks.
- R4: `maint_flag` is 1, and `off_lamp_n` and `warn_lamp_n` are 0, exactly when at least one current fault exists.
- R5: `led_n` is 0 exactly when a current fault exists on a bit other than bit 5 (input-data loss).
- R6: One cycle after a bit becomes current, the matching `hist_image` bit is set. It stays set after the fault goes away.
- R7: A `hist_clr` pulse loads the history image with the current-fault vector of that cycle. Without `hist_clr`, no history bit ever falls.
- R8: In SER_IDLE, a `ser_start` pulse sends a frame of 2·N bits on `ser_bit`, LSB first, with `ser_valid` high for exactly 2·N cycles. Bits 0..N-1 are the current faults and bits N..2N-1 are the history, both taken in the start cycle.
- R9: A `ser_start` during a frame is ignored. The running frame keeps its content and length, and no extra frame follows.
- R10: After reset, no fault is current, the history is zero, all active-low lines are 1, `maint_flag` is 0 and `ser_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Qualification strobe |
| fault_in | input | N_FLT | Raw fault inputs, 1 = fault |
| hist_clr | input | 1 | Shop-test history clear |
| ser_start | input | 1 | Start a status frame |
| maint_flag | output | 1 | Fault gate, 1 = any current fault |
| led_n | output | 1 | Front-panel LED, active low, excludes data loss |
| off_lamp_n | output | 1 | OFF lamp, active low |
| warn_lamp_n | output | 1 | External warning, active low |
| hist_image | output | N_FLT | History register image |
| ser_bit | output | 1 | Serial status bit |
| ser_valid | output | 1 | Frame bit valid |

## Verification
A single fault is held for three ticks and then a fourth, which shows the exact qualification edge. A fault held for three ticks, broken once and held for three more must stay unqualified, which separates a consecutive count from a cumulative one. A data-loss-only fault is used to tell the LED apart from the fault gate. A long run with no strobes checks that the inputs are ignored between ticks. Frames are taken with mixed, all-set and cleared histories, including a second start request during a frame. These cases detect swapped halves, a wrong bit order and frames that restart.

// File: rtl/fault_agg_pkg.sv
package fault_agg_pkg;
    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_t;
endpackage

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
    parameter int N_FLT = 7,
    parameter int QUAL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [N_FLT-1:0] fault_in,
    output logic [N_FLT-1:0] cur
);
    localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;

    for (genvar k = 0; k < N_FLT; k++) begin : g_bit
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt    <= '0;
                cur[k] <= 1'b0;
            end else if (sample_tick) begin
                if (!fault_in[k]) begin
                    cnt    <= '0;
                    cur[k] <= 1'b0;
                end else if (!cur[k]) begin
                    if (cnt == CW'(QUAL - 1)) cur[k] <= 1'b1;
                    else                      cnt    <= cnt + 1'b1;
                end
            end
        end

        // R1: no change between strobes
        a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !sample_tick |=> $stable(cur[k]));
        // R3: low sample drops the bit
        a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_tick && !fault_in[k]) |=> !cur[k]);
        // R2: a rise only follows a high sample
        a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cur[k]) |-> $past(sample_tick && fault_in[k]));
    end
endmodule

// File: rtl/fault_history.sv
module fault_history #(
    parameter int N_FLT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hist_clr,
    input  logic [N_FLT-1:0] cur,
    output logic [N_FLT-1:0] hist
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (hist_clr) hist <= cur;
        else               hist <= hist | cur;
    end

    // R6: sticky unless cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_clr |=> ((hist & $past(hist)) == $past(hist)));
    // R7: clear loads the current vector
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hist_clr |=> (hist == $past(cur)));
endmodule

// File: rtl/status_serializer.sv
module status_serializer
    import fault_agg_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_start,
    input  logic [WORD_W-1:0] word,
    output logic              ser_bit,
    output logic              ser_valid
);
    localparam int CNT_W = $clog2(WORD_W);

    ser_state_t        state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              last;

    assign last = (cnt == CNT_W'(WORD_W - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE:  if (ser_start) state_nx = SER_SHIFT;
            SER_SHIFT: if (last)      state_nx = SER_IDLE;
            default:                  state_nx = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SER_IDLE;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                SER_IDLE: if (ser_start) begin
                    shreg <= word;
                    cnt   <= '0;
                end
                SER_SHIFT: begin
                    shreg <= shreg >> 1;
                    cnt   <= cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        ser_valid = (state == SER_SHIFT);
        ser_bit   = ser_valid & shreg[0];
    end

    // R9: a frame runs to its end
    a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT && !last) |=> (state == SER_SHIFT));
    // R8: frame ends after its last bit
    a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT && last) |=> (state == SER_IDLE));
endmodule

// File: rtl/fault_aggregator.sv
module fault_aggregator #(
    parameter int N_FLT    = 7,
    parameter int QUAL     = 4,
    parameter int LOSS_IDX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [N_FLT-1:0] fault_in,
    input  logic             hist_clr,
    input  logic             ser_start,
    output logic             maint_flag,
    output logic             led_n,
    output logic             off_lamp_n,
    output logic             warn_lamp_n,
    output logic [N_FLT-1:0] hist_image,
    output logic             ser_bit,
    output logic             ser_valid
);
    localparam int WORD_W = 2 * N_FLT;
    localparam logic [N_FLT-1:0] LED_MASK = ~(N_FLT'(1) << LOSS_IDX);

    logic [N_FLT-1:0] cur;

    fault_qualifier #(.N_FLT(N_FLT), .QUAL(QUAL)) u_qual (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .fault_in(fault_in), .cur(cur));

    fault_history #(.N_FLT(N_FLT)) u_hist (
        .clk(clk), .rst_n(rst_n), .hist_clr(hist_clr),
        .cur(cur), .hist(hist_image));

    status_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .ser_start(ser_start),
        .word({hist_image, cur}), .ser_bit(ser_bit), .ser_valid(ser_valid));

    always_comb begin
        maint_flag  = |cur;
        off_lamp_n  = ~maint_flag;
        warn_lamp_n = ~maint_flag;
        led_n       = ~|(cur & LED_MASK);
    end

    // R5: LED only ever lit with the gate set
    a_r5_led_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !led_n |-> maint_flag);
    // R6: a current fault is in the history one cycle later
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        maint_flag |=> (hist_image != '0));
endmodule

// File: tb/test_fault_aggregator.sv
module test_fault_aggregator;
    localparam int N  = 7;
    localparam int FW = 2 * N;
    localparam int LOSS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_tick = 1'b0;
    logic [N-1:0] fault_in = '0;
    logic hist_clr = 1'b0;
    logic ser_start = 1'b0;
    logic maint_flag, led_n, off_lamp_n, warn_lamp_n, ser_bit, ser_valid;
    logic [N-1:0] hist_image;

    always #2 clk = ~clk;

    fault_aggregator i_fault_aggregator (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fault_in(fault_in),
        .hist_clr(hist_clr), .ser_start(ser_start), .maint_flag(maint_flag),
        .led_n(led_n), .off_lamp_n(off_lamp_n), .warn_lamp_n(warn_lamp_n),
        .hist_image(hist_image), .ser_bit(ser_bit), .ser_valid(ser_valid));

    int n_cmp = 0;
    int n_bad = 0;
    int qcnt [N];
    logic [N-1:0] mcur = '0;
    logic [N-1:0] mhist = '0;
    logic [FW-1:0] exp_q [$];

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        cmp({tag, " R4 flag"}, 32'(maint_flag), 32'(|mcur));
        cmp({tag, " R4 off"}, 32'(off_lamp_n), 32'(~|mcur));
        cmp({tag, " R4 warn"}, 32'(warn_lamp_n), 32'(~|mcur));
        cmp({tag, " R5 led"}, 32'(led_n), 32'(~|(mcur & ~(N'(1) << LOSS))));
        cmp({tag, " R6 hist"}, 32'(hist_image), 32'(mhist));
    endtask

    task automatic tick(input logic [N-1:0] v);
        @(negedge clk);
        fault_in = v;
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        for (int k = 0; k < N; k++) begin
            qcnt[k] = v[k] ? ((qcnt[k] < 4) ? qcnt[k] + 1 : 4) : 0;
            mcur[k] = (qcnt[k] == 4);
        end
        @(negedge clk);
        mhist = mhist | mcur;
    endtask

    task automatic clear_hist();
        @(negedge clk);
        hist_clr = 1'b1;
        @(negedge clk);
        hist_clr = 1'b0;
        mhist = mcur;
    endtask

    task automatic frame(input bit restart);
        @(negedge clk);
        ser_start = 1'b1;
        exp_q.push_back({mhist, mcur});
        @(negedge clk);
        ser_start = 1'b0;
        if (restart) begin
            repeat (4) @(negedge clk);
            ser_start = 1'b1;
            @(negedge clk);
            ser_start = 1'b0;
        end
        repeat (FW + 3) @(negedge clk);
    endtask

    // monitor: gathers frames and compares them with the queue
    logic [FW-1:0] rx;
    int bcnt = 0;
    always @(negedge clk) begin
        if (ser_valid) begin
            if (bcnt < FW) rx[bcnt] = ser_bit;
            bcnt++;
        end else if (bcnt != 0) begin
            cmp("R8 frame length", 32'(bcnt), 32'(FW));
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9 unexpected frame act=%0h exp=none", rx);
            end else begin
                cmp("R8 R9 frame word", 32'(rx), 32'(exp_q.pop_front()));
            end
            bcnt = 0;
        end
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog act=running exp=done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none
        for (int k = 0; k < N; k++) qcnt[k] = 0;
        repeat (3) @(negedge clk);
        check_outs("R10 reset");
        cmp("R10 ser_valid", 32'(ser_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: three ticks not enough, fourth qualifies
        repeat (3) tick(7'b0000001);
        check_outs("R2 three ticks");
        cmp("R2 not yet", 32'(maint_flag), 32'd0);
        tick(7'b0000001);
        check_outs("R2 fourth tick");
        cmp("R2 qualified", 32'(maint_flag), 32'd1);

        // R3: low tick drops at once, R6 history kept
        tick(7'b0000000);
        check_outs("R3 drop");
        cmp("R6 sticky", 32'(hist_image[0]), 32'd1);

        // R5: data loss lights lamps but not LED
        repeat (4) tick(7'b0100000);
        check_outs("R5 loss only");
        cmp("R5 led dark", 32'(led_n), 32'd1);

        // R1: no strobe, inputs ignored
        @(negedge clk);
        fault_in = '1;
        repeat (6) @(negedge clk);
        check_outs("R1 no strobe");
        fault_in = '0;
        @(negedge clk);

        // R3: a broken run never qualifies
        repeat (3) tick(7'b0100010);
        tick(7'b0100000);
        repeat (3) tick(7'b0100010);
        check_outs("R3 broken run");
        cmp("R3 bit1 idle", 32'(hist_image[1]), 32'd0);

        // R8: frame with mixed history
        frame(1'b0);

        // R7: clear loads current vector
        repeat (4) tick(7'b1100000);
        check_outs("R7 before clear");
        clear_hist();
        check_outs("R7 after clear");
        cmp("R7 hist eq cur", 32'(hist_image), 32'(7'b1100000));

        // R9: restart request during a frame
        frame(1'b1);

        // all faults
        repeat (4) tick('1);
        check_outs("R4 all faults");
        frame(1'b0);
        tick('0);
        clear_hist();
        check_outs("R7 cleared empty");
        frame(1'b0);

        cmp("R9 queue drained", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule